// File: doc/BRIEF.md
# Double-Size Bilinear Pixel Interpolator

This block is the arithmetic stage of a 2x image upscaler. Each accepted beat presents two pixels from the same column: one from the row above and one from the current row. A controller supplies a two-bit select that chooses the output pixel. It can pass the original pixel through, average two pixels horizontally, average two pixels vertically, or average the four pixels around a central point. Because every weight is either 0 or one half, each average is a sum followed by a right shift. The datapath has no multipliers and uses four adders.

A two-entry register bank keeps the column pair from the most recent accepted beat. This lets the left and right neighbours of a central point be used in the same cycle. Two boundary flags mark the last output column and the last output row. When a flag is set, the missing neighbour is replaced by copying the pixel nearest to it, so the edge repeats its inner neighbour. Line memory, counters and frame timing belong to the surrounding logic.

Top module: `bilin2x_interp`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_px` is 0. A beat accepted with `in_valid`=1 produces `out_valid`=1 exactly one clock later. A cycle with `in_valid`=0 gives `out_valid`=0 one clock later.
- R2: When `mix_sel`=2'b00, the output is `row_cur` of that beat.
- R3: When `mix_sel`=2'b01 and `edge_col`=0, the output is floor((L + `row_cur`)/2). L is the `row_cur` of the most recent earlier accepted beat.
- R4: When `mix_sel`=2'b10 and `edge_row`=0, the output is floor((`row_prev` + `row_cur`)/2).
- R5: When `mix_sel`=2'b11 and neither boundary flag is set, the output is floor((LP + L + `row_prev` + `row_cur`)/4). LP is the `row_prev` of the most recent earlier accepted beat. The result is exact even when all four pixels are at full scale.
- R6: Beats with `in_valid`=0 do not change the stored left pair.
- R7: With `edge_col`=1, `mix_sel`=2'b01 gives L, and `mix_sel`=2'b11 with `edge_row`=0 gives floor((LP + L)/2).
- R8: With `edge_row`=1, `mix_sel`=2'b10 gives `row_cur`, and `mix_sel`=2'b11 with `edge_col`=0 gives floor((L + `row_cur`)/2).
- R9: With both `edge_col` and `edge_row` set, `mix_sel`=2'b11 gives L.
- R10: `out_px` keeps its value through cycles with `in_valid`=0.
- R11: Reset clears the stored left pair to zero. A horizontal beat as the first beat after reset therefore gives floor(`row_cur`/2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Beat qualifier |
| row_prev | input | PIX_W | Pixel from the row above, current column |
| row_cur | input | PIX_W | Pixel from the current row, current column |
| mix_sel | input | 2 | 00 copy, 01 horizontal, 10 vertical, 11 central |
| edge_col | input | 1 | Beat produces the last output column |
| edge_row | input | 1 | Beat produces the last output row |
| out_valid | output | 1 | Output pixel qualifier |
| out_px | output | PIX_W | Interpolated output pixel |

## Verification
The hardest state to reach is one where the stored left pair differs from the previous beat on the ports. This happens after idle cycles that present different pixel values. The stimulus inserts `in_valid`=0 beats that carry other data between two accepted beats. A horizontal or central beat then shows whether the neighbour came from the last accepted beat. Full-scale pixels in a central beat exercise the guard bits. Every combination of the two boundary flags with the averaging selects is also driven.

// File: rtl/bl2_pkg.sv
package bl2_pkg;

    localparam int DEFAULT_PIX_W = 18;
    localparam int GUARD_BITS    = 2;

    typedef enum logic [1:0] {
        MIX_COPY = 2'b00,
        MIX_HORZ = 2'b01,
        MIX_VERT = 2'b10,
        MIX_QUAD = 2'b11
    } mix_kind_t;

    typedef struct packed {
        logic col_end;
        logic row_end;
    } edge_t;

endpackage

// File: rtl/bl2_pair_bank.sv
module bl2_pair_bank #(
    parameter int PIX_W = bl2_pkg::DEFAULT_PIX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [PIX_W-1:0] d_prev,
    input  logic [PIX_W-1:0] d_cur,
    output logic [PIX_W-1:0] q_prev,
    output logic [PIX_W-1:0] q_cur
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_prev <= '0;
            q_cur  <= '0;
        end else if (load) begin
            q_prev <= d_prev;
            q_cur  <= d_cur;
        end
    end

endmodule

// File: rtl/bl2_mix_core.sv
module bl2_mix_core
    import bl2_pkg::*;
#(
    parameter int PIX_W = DEFAULT_PIX_W
) (
    input  mix_kind_t        kind,
    input  edge_t            edges,
    input  logic [PIX_W-1:0] lft_prev,
    input  logic [PIX_W-1:0] lft_cur,
    input  logic [PIX_W-1:0] rgt_prev,
    input  logic [PIX_W-1:0] rgt_cur,
    output logic [PIX_W-1:0] result
);

    localparam int SW = PIX_W + GUARD_BITS;

    logic [SW-1:0] s_left;   // left column, vertical pair
    logic [SW-1:0] s_right;  // right column, vertical pair
    logic [SW-1:0] s_row;    // current row, horizontal pair
    logic [SW-1:0] s_all;    // four-pixel sum

    always_comb begin
        s_left  = SW'(lft_prev) + SW'(lft_cur);
        s_right = SW'(rgt_prev) + SW'(rgt_cur);
        s_row   = SW'(lft_cur)  + SW'(rgt_cur);
        s_all   = s_left + s_right;
    end

    always_comb begin
        result = rgt_cur;
        unique case (kind)
            MIX_COPY: result = rgt_cur;
            MIX_HORZ: result = edges.col_end ? lft_cur : s_row[PIX_W:1];
            MIX_VERT: result = edges.row_end ? rgt_cur : s_right[PIX_W:1];
            MIX_QUAD: begin
                unique case ({edges.col_end, edges.row_end})
                    2'b00: result = s_all[PIX_W+1:2];
                    2'b10: result = s_left[PIX_W:1];
                    2'b01: result = s_row[PIX_W:1];
                    2'b11: result = lft_cur;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/bilin2x_interp.sv
module bilin2x_interp
    import bl2_pkg::*;
#(
    parameter int PIX_W = DEFAULT_PIX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] row_prev,
    input  logic [PIX_W-1:0] row_cur,
    input  logic [1:0]       mix_sel,
    input  logic             edge_col,
    input  logic             edge_row,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_px
);

    logic [PIX_W-1:0] left_prev;
    logic [PIX_W-1:0] left_cur;
    logic [PIX_W-1:0] mixed;
    edge_t            edges;

    assign edges = '{col_end: edge_col, row_end: edge_row};

    bl2_pair_bank #(.PIX_W(PIX_W)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .load   (in_valid),
        .d_prev (row_prev),
        .d_cur  (row_cur),
        .q_prev (left_prev),
        .q_cur  (left_cur)
    );

    bl2_mix_core #(.PIX_W(PIX_W)) u_core (
        .kind     (mix_kind_t'(mix_sel)),
        .edges    (edges),
        .lft_prev (left_prev),
        .lft_cur  (left_cur),
        .rgt_prev (row_prev),
        .rgt_cur  (row_cur),
        .result   (mixed)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_px    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_px <= mixed;
        end
    end

endmodule

// File: rtl/bilin2x_checker.sv
module bilin2x_checker #(
    parameter int PIX_W = bl2_pkg::DEFAULT_PIX_W
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [PIX_W-1:0] row_prev,
    input logic [PIX_W-1:0] row_cur,
    input logic [1:0]       mix_sel,
    input logic             edge_col,
    input logic             edge_row,
    input logic [PIX_W-1:0] left_prev,
    input logic [PIX_W-1:0] left_cur,
    input logic             out_valid,
    input logic [PIX_W-1:0] out_px
);

    a_r1_valid_follow: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r1_idle_follow: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_px));

    a_r6_bank_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(left_prev) && $stable(left_cur)));

    a_r2_copy: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mix_sel == 2'b00) |=> out_px == $past(row_cur));

    a_r4_vert_between: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mix_sel == 2'b10 && !edge_row) |=>
            (($past(row_prev) <= $past(row_cur)) ?
                (out_px >= $past(row_prev) && out_px <= $past(row_cur)) :
                (out_px >= $past(row_cur) && out_px <= $past(row_prev))));

    a_r7_edge_copy: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mix_sel == 2'b01 && edge_col) |=> out_px == $past(left_cur));

    a_r8_row_edge: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mix_sel == 2'b10 && edge_row) |=> out_px == $past(row_cur));

    a_r9_corner: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mix_sel == 2'b11 && edge_row && edge_col) |=>
            out_px == $past(left_cur));

endmodule

bind bilin2x_interp bilin2x_checker #(.PIX_W(PIX_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .row_prev  (row_prev),
    .row_cur   (row_cur),
    .mix_sel   (mix_sel),
    .edge_col  (edge_col),
    .edge_row  (edge_row),
    .left_prev (left_prev),
    .left_cur  (left_cur),
    .out_valid (out_valid),
    .out_px    (out_px)
);

// File: tb/bilin2x_interp_test.sv
`timescale 1ns/1ps
module bilin2x_interp_test;

    localparam int PIX_W = 18;
    localparam int PMAX  = (1 << PIX_W) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [PIX_W-1:0] row_prev = '0;
    logic [PIX_W-1:0] row_cur = '0;
    logic [1:0]       mix_sel = 2'b00;
    logic             edge_col = 1'b0;
    logic             edge_row = 1'b0;
    logic             out_valid;
    logic [PIX_W-1:0] out_px;

    int n_run  = 0;
    int n_fail = 0;
    int m_lp   = 0;   // model of left pair
    int m_lc   = 0;
    int exp_px = 0;

    always #2 clk = ~clk;

    bilin2x_interp #(.PIX_W(PIX_W)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .row_prev(row_prev), .row_cur(row_cur), .mix_sel(mix_sel),
        .edge_col(edge_col), .edge_row(edge_row),
        .out_valid(out_valid), .out_px(out_px)
    );

    task automatic check(input string req, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic int model(input int k, input bit ec, input bit er,
                                 input int p, input int c);
        case (k)
            0: return c;
            1: return ec ? m_lc : (m_lc + c) / 2;
            2: return er ? c : (p + c) / 2;
            default: begin
                if (ec && er) return m_lc;
                if (ec)       return (m_lp + m_lc) / 2;
                if (er)       return (m_lc + c) / 2;
                return (m_lp + m_lc + p + c) / 4;
            end
        endcase
    endfunction

    task automatic beat(input bit v, input int k, input bit ec, input bit er,
                        input int p, input int c);
        @(negedge clk);
        in_valid = v; mix_sel = 2'(k); edge_col = ec; edge_row = er;
        row_prev = PIX_W'(p); row_cur = PIX_W'(c);
        if (v) begin
            exp_px = model(k, ec, er, p, c);
            m_lp = p; m_lc = c;
        end
        @(posedge clk); #1;
    endtask

    task automatic do_reset;
        @(negedge clk); rst = 1'b1; in_valid = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        m_lp = 0; m_lc = 0;
        check("R1 reset valid", int'(out_valid), 0);
        check("R1 reset px", int'(out_px), 0);
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_copy_valid;
        beat(1, 0, 0, 0, 1000, 2345);
        check("R1 valid after beat", int'(out_valid), 1);
        check("R2 copy", int'(out_px), 2345);
        beat(0, 0, 0, 0, 7, 9);
        check("R1 idle valid", int'(out_valid), 0);
        check("R10 hold", int'(out_px), 2345);
    endtask

    task automatic t_first_horz;
        do_reset();
        beat(1, 1, 0, 0, 50, 301);
        check("R11 first horizontal", int'(out_px), 150);
    endtask

    task automatic t_horz_vert;
        beat(1, 0, 0, 0, 10, 100);
        beat(1, 1, 0, 0, 20, 203);
        check("R3 horizontal", int'(out_px), exp_px);
        beat(1, 2, 0, 0, 11, 40);
        check("R4 vertical", int'(out_px), 25);
        beat(1, 2, 0, 0, 40, 11);
        check("R4 vertical swapped", int'(out_px), 25);
    endtask

    task automatic t_quad;
        beat(1, 0, 0, 0, 1, 2);
        beat(1, 3, 0, 0, 3, 5);
        check("R5 central", int'(out_px), 2);
        beat(1, 0, 0, 0, PMAX, PMAX);
        beat(1, 3, 0, 0, PMAX, PMAX);
        check("R5 central full scale", int'(out_px), PMAX);
        beat(1, 3, 0, 0, PMAX, PMAX - 2);
        check("R5 central near full", int'(out_px), PMAX - 1);
    endtask

    task automatic t_idle_bank;
        beat(1, 0, 0, 0, 400, 800);
        beat(0, 0, 0, 0, 9000, 9000);
        beat(0, 3, 1, 1, 12345, 5432);
        beat(1, 1, 0, 0, 0, 0);
        check("R6 idle keeps left cur", int'(out_px), 400);
        beat(1, 0, 0, 0, 600, 1000);
        beat(0, 1, 0, 0, 3, 3);
        beat(1, 3, 1, 0, 7, 7);
        check("R6 idle keeps left pair", int'(out_px), 800);
    endtask

    task automatic t_edges;
        beat(1, 0, 0, 0, 70, 90);
        beat(1, 1, 1, 0, 5, 5);
        check("R7 last col horizontal", int'(out_px), 90);
        beat(1, 0, 0, 0, 31, 60);
        beat(1, 3, 1, 0, 999, 999);
        check("R7 last col central", int'(out_px), 45);
        beat(1, 2, 0, 1, 777, 321);
        check("R8 last row vertical", int'(out_px), 321);
        beat(1, 0, 0, 0, 0, 10);
        beat(1, 3, 0, 1, 5000, 21);
        check("R8 last row central", int'(out_px), 15);
        beat(1, 0, 0, 0, 1, 4242);
        beat(1, 3, 1, 1, 8, 8);
        check("R9 corner central", int'(out_px), 4242);
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        t_copy_valid();
        t_first_horz();
        t_horz_vert();
        t_quad();
        t_idle_bank();
        t_edges();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule